// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit linear address into a physical address. It reads two 4-byte entries from a page table held in memory. The top ten address bits pick an entry in a root table. The physical base of that root table comes from a base register that privileged software loads. The entry read there names the frame of a second table. The middle ten bits pick an entry in that second table, and its frame number, joined to the low twelve bits, gives the physical address. Both levels use one entry layout. Bit 0 marks the entry valid, bit 1 allows writes, bit 2 allows user-mode access, and bits 31..12 hold a frame number.

A requester offers one translation at a time, with a write flag and a user-mode flag, through a valid/ready pair. The walker takes the base register value when it accepts the request. It then issues at most two reads on a memory port that has only one read outstanding. The port holds its request and address until the read data arrives. The walker reports the outcome with a one-cycle done pulse and a fault flag. The translation faults if an entry at either level is not present, or if it forbids the access. On a fault, the walker keeps the faulting linear address in a register, which a handler can read to restart the access.

Top module: `pt_walker`

## Requirements
- R1: After reset, req_ready is 1, rsp_done is 0, rsp_fault is 0, mem_req is 0 and fault_addr is 0.
- R2: The first memory read of a walk goes to {root_base[31:12], req_vaddr[31:22], 2'b00}.
- R3: When the root entry permits the access, the second read goes to {root_entry[31:12], req_vaddr[21:12], 2'b00}.
- R4: A walk that succeeds drives rsp_done high for exactly one cycle, with rsp_fault 0 and rsp_paddr = {leaf_entry[31:12], req_vaddr[11:0]}.
- R5: If bit 0 of the root entry is 0, the walk ends with rsp_fault 1 after that single read, and the second-level table is not read.
- R6: If bit 0 of the second-level entry is 0, the walk ends with rsp_fault 1.
- R7: A request with req_user 1 faults when bit 2 is 0 in the entry at either level. With req_user 0, bit 2 has no effect.
- R8: A request with req_write 1 faults when bit 1 is 0 in the entry at either level. With req_write 0, bit 1 has no effect.
- R9: On every fault, fault_addr takes the linear address of the failed request. It keeps that value through later successful walks.
- R10: From acceptance until rsp_done, req_ready stays 0. While mem_req is 1 and no read data has returned, mem_addr stays constant.
- R11: Entry bits 11..3 (software, accessed, dirty and reserved) have no effect on addresses, results or faults.
- R12: The walker samples root_base when it accepts a request. Later changes to root_base do not affect that walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| root_base | input | 32 | Physical base of the root table (bits 31..12 used) |
| req_valid | input | 1 | Translation request offered |
| req_ready | output | 1 | Walker idle and able to accept |
| req_vaddr | input | 32 | Linear address to translate |
| req_write | input | 1 | Access is a write |
| req_user | input | 1 | Access comes from user mode |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_fault | output | 1 | Completed walk faulted (valid with rsp_done) |
| rsp_paddr | output | 32 | Physical address of the last successful walk |
| fault_addr | output | 32 | Linear address of the most recent fault |
| mem_req | output | 1 | Memory read requested |
| mem_addr | output | 32 | Byte address of the entry being read |
| mem_rvalid | input | 1 | Read data returned for the held request |
| mem_rdata | input | 32 | Entry read from memory |

## Verification
The bench targets the order of the permission checks. A design that checked only the leaf would let a user or write access through a root entry that forbids it. A design that read the second table after a root fault would issue a stray read, and the bench counts that read. Entries with the software and status bits set are translated next to copies with those bits clear, so any decode of bits 11..3 shows up as a different result. The bench also moves root_base during a walk and runs successful walks after a fault. This exposes a design that reads the base register live, or one that lets fault_addr follow addresses that did not fault.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int unsigned ENT_PRESENT = 0;
  localparam int unsigned ENT_WRITE   = 1;
  localparam int unsigned ENT_USER    = 2;

  typedef enum logic [1:0] {
    WALK_IDLE = 2'd0,
    WALK_ROOT = 2'd1,
    WALK_LEAF = 2'd2
  } walk_state_e;
endpackage

// File: rtl/ptw_rst_sync.sv
module ptw_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen #(
  parameter int unsigned OFF_W = 12,
  parameter int unsigned IDX_W = 10
) (
  input  logic                       use_leaf,
  input  logic [OFF_W+2*IDX_W-1:OFF_W] root_frame,
  input  logic [OFF_W+2*IDX_W-1:OFF_W] leaf_frame,
  input  logic [OFF_W+2*IDX_W-1:0]   vaddr,
  output logic [OFF_W+2*IDX_W-1:0]   ent_addr
);
  localparam int unsigned ADDR_W  = OFF_W + 2*IDX_W;
  localparam int unsigned ENT_LOG = OFF_W - IDX_W;

  logic [IDX_W-1:0] idx;
  logic [ADDR_W-1:OFF_W] frame;

  always_comb begin
    if (use_leaf) begin
      idx   = vaddr[OFF_W+IDX_W-1 -: IDX_W];
      frame = leaf_frame;
    end else begin
      idx   = vaddr[ADDR_W-1 -: IDX_W];
      frame = root_frame;
    end
    ent_addr = {frame, idx, {ENT_LOG{1'b0}}};
  end
endmodule

// File: rtl/ptw_entry_chk.sv
module ptw_entry_chk #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned OFF_W  = 12
) (
  input  logic [ADDR_W-1:0]     entry,
  input  logic                  is_user,
  input  logic                  is_write,
  output logic                  allow,
  output logic [ADDR_W-1:OFF_W] frame
);
  import ptw_pkg::*;

  logic user_ok, write_ok;

  always_comb begin
    user_ok  = !is_user  || entry[ENT_USER];
    write_ok = !is_write || entry[ENT_WRITE];
    allow    = entry[ENT_PRESENT] && user_ok && write_ok;
    frame    = entry[ADDR_W-1:OFF_W];
  end
endmodule

// File: rtl/pt_walker.sv
module pt_walker #(
  parameter int unsigned OFF_W = 12,
  parameter int unsigned IDX_W = 10,
  localparam int unsigned ADDR_W = OFF_W + 2*IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] root_base,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_vaddr,
  input  logic              req_write,
  input  logic              req_user,
  output logic              rsp_done,
  output logic              rsp_fault,
  output logic [ADDR_W-1:0] rsp_paddr,
  output logic [ADDR_W-1:0] fault_addr,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_rvalid,
  input  logic [ADDR_W-1:0] mem_rdata
);
  import ptw_pkg::*;

  logic rst_n_int;

  walk_state_e           state_q, state_d;
  logic [ADDR_W-1:0]     va_q;
  logic                  wr_q, usr_q;
  logic [ADDR_W-1:OFF_W] root_q, leaf_q;
  logic                  done_q, fault_q;
  logic [ADDR_W-1:0]     paddr_q, faddr_q;

  logic                  cap_en, leaf_en, finish, fin_ok;
  logic                  ent_allow;
  logic [ADDR_W-1:OFF_W] ent_frame;

  ptw_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  ptw_addr_gen #(.OFF_W(OFF_W), .IDX_W(IDX_W)) u_addr (
    .use_leaf   (state_q == WALK_LEAF),
    .root_frame (root_q),
    .leaf_frame (leaf_q),
    .vaddr      (va_q),
    .ent_addr   (mem_addr)
  );

  ptw_entry_chk #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_chk (
    .entry    (mem_rdata),
    .is_user  (usr_q),
    .is_write (wr_q),
    .allow    (ent_allow),
    .frame    (ent_frame)
  );

  always_comb begin
    state_d = state_q;
    cap_en  = 1'b0;
    leaf_en = 1'b0;
    finish  = 1'b0;
    fin_ok  = 1'b0;
    case (state_q)
      WALK_IDLE: begin
        if (req_valid) begin
          cap_en  = 1'b1;
          state_d = WALK_ROOT;
        end
      end
      WALK_ROOT: begin
        if (mem_rvalid) begin
          if (ent_allow) begin
            leaf_en = 1'b1;
            state_d = WALK_LEAF;
          end else begin
            finish  = 1'b1;
            state_d = WALK_IDLE;
          end
        end
      end
      WALK_LEAF: begin
        if (mem_rvalid) begin
          finish  = 1'b1;
          fin_ok  = ent_allow;
          state_d = WALK_IDLE;
        end
      end
      default: state_d = WALK_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      state_q <= WALK_IDLE;
      va_q    <= '0;
      wr_q    <= 1'b0;
      usr_q   <= 1'b0;
      root_q  <= '0;
      leaf_q  <= '0;
      done_q  <= 1'b0;
      fault_q <= 1'b0;
      paddr_q <= '0;
      faddr_q <= '0;
    end else begin
      state_q <= state_d;
      done_q  <= finish;
      if (cap_en) begin
        va_q   <= req_vaddr;
        wr_q   <= req_write;
        usr_q  <= req_user;
        root_q <= root_base[ADDR_W-1:OFF_W];
      end
      if (leaf_en) leaf_q <= ent_frame;
      if (finish)  fault_q <= !fin_ok;
      if (finish && fin_ok)  paddr_q <= {ent_frame, va_q[OFF_W-1:0]};
      if (finish && !fin_ok) faddr_q <= va_q;
    end
  end

  assign req_ready  = (state_q == WALK_IDLE);
  assign mem_req    = (state_q != WALK_IDLE);
  assign rsp_done   = done_q;
  assign rsp_fault  = fault_q;
  assign rsp_paddr  = paddr_q;
  assign fault_addr = faddr_q;
endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned OFF_W  = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ADDR_W-1:0] req_vaddr,
  input logic              rsp_done,
  input logic              rsp_fault,
  input logic [ADDR_W-1:0] rsp_paddr,
  input logic [ADDR_W-1:0] fault_addr,
  input logic              mem_req,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_rvalid
);
  logic [ADDR_W-1:0] seen_va_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_va_q <= '0;
    else if (req_valid && req_ready) seen_va_q <= req_vaddr;
  end

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !mem_req);

  assert_done_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);

  assert_offset_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_done && !rsp_fault) |-> (rsp_paddr[OFF_W-1:0] == seen_va_q[OFF_W-1:0]));

  assert_fault_va_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_done && rsp_fault) |-> (fault_addr == seen_va_q));

  assert_fault_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_done && !rsp_fault) |-> $stable(fault_addr));

  assert_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  assert_hold_addr_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_addr)));
endmodule

bind pt_walker pt_walker_chk #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_pt_walker_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .req_vaddr  (req_vaddr),
  .rsp_done   (rsp_done),
  .rsp_fault  (rsp_fault),
  .rsp_paddr  (rsp_paddr),
  .fault_addr (fault_addr),
  .mem_req    (mem_req),
  .mem_addr   (mem_addr),
  .mem_rvalid (mem_rvalid)
);

// File: tb/pt_walker_bench.sv
`timescale 1ns/1ps
module pt_walker_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] root_base;
  logic        req_valid;
  logic        req_ready;
  logic [31:0] req_vaddr;
  logic        req_write, req_user;
  logic        rsp_done, rsp_fault;
  logic [31:0] rsp_paddr, fault_addr;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_rvalid;
  logic [31:0] mem_rdata;

  int unsigned n_tests = 0;
  int unsigned n_fail  = 0;

  logic [31:0] mem [logic [31:0]];
  logic [31:0] rd_log [2];
  int unsigned rd_cnt;
  logic [31:0] exp_faddr;

  always #2.5 clk = ~clk;

  pt_walker u_pt_walker (
    .clk(clk), .rst_n(rst_n), .root_base(root_base),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .req_write(req_write), .req_user(req_user),
    .rsp_done(rsp_done), .rsp_fault(rsp_fault), .rsp_paddr(rsp_paddr),
    .fault_addr(fault_addr), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] rd(input logic [31:0] a);
    if (mem.exists(a)) return mem[a];
    return 32'h0;
  endfunction

  function automatic logic perm_ok(input logic [31:0] e, input logic wr, input logic usr);
    return e[0] && (!usr || e[2]) && (!wr || e[1]);
  endfunction

  // memory responder: random latency, one read in flight
  initial begin
    int unsigned cnt;
    int unsigned lat;
    cnt = 0;
    lat = 0;
    mem_rvalid = 1'b0;
    mem_rdata  = '0;
    forever begin
      @(negedge clk);
      mem_rvalid = 1'b0;
      if (mem_req) begin
        if (cnt >= lat) begin
          mem_rvalid = 1'b1;
          mem_rdata  = rd(mem_addr);
          if (rd_cnt < 2) rd_log[rd_cnt] = mem_addr;
          rd_cnt++;
          cnt = 0;
          lat = $urandom_range(0, 3);
        end else begin
          cnt++;
        end
      end
    end
  end

  // run one walk and compare against a model
  task automatic walk(input string tag, input logic [31:0] base, input logic [31:0] va,
                      input logic wr, input logic usr, input logic move_base);
    logic [31:0] pde_a, pde, pte_a, pte, exp_pa;
    logic        exp_fault;
    int unsigned exp_reads;
    int unsigned guard;
    pde_a = {base[31:12], va[31:22], 2'b00};
    pde   = rd(pde_a);
    pte_a = {pde[31:12], va[21:12], 2'b00};
    pte   = rd(pte_a);
    if (!perm_ok(pde, wr, usr)) begin
      exp_fault = 1'b1; exp_reads = 1; exp_pa = 32'h0;
    end else begin
      exp_reads = 2;
      exp_fault = !perm_ok(pte, wr, usr);
      exp_pa    = {pte[31:12], va[11:0]};
    end
    rd_cnt    = 0;
    root_base = base;
    req_vaddr = va;
    req_write = wr;
    req_user  = usr;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    if (move_base) root_base = ~base;
    guard = 0;
    while (!rsp_done && guard < 64) begin
      if (req_ready) check({tag, " R10 ready low while busy"}, 32'(req_ready), 32'h0);
      @(negedge clk);
      guard++;
    end
    check({tag, " R4 done seen"}, 32'(rsp_done), 32'h1);
    check({tag, " R2 root read addr"}, rd_log[0], pde_a);
    check({tag, " R5 read count"}, rd_cnt, exp_reads);
    if (exp_reads == 2) check({tag, " R3 leaf read addr"}, rd_log[1], pte_a);
    check({tag, " R6 R7 R8 fault flag"}, 32'(rsp_fault), 32'(exp_fault));
    if (!exp_fault) check({tag, " R4 paddr"}, rsp_paddr, exp_pa);
    if (exp_fault) exp_faddr = va;
    check({tag, " R9 fault_addr"}, fault_addr, exp_faddr);
    @(negedge clk);
    check({tag, " R4 single pulse"}, 32'(rsp_done), 32'h0);
  endtask

  task automatic setup(input logic [31:0] base, input logic [31:0] va,
                       input logic [31:0] pde, input logic [31:0] pte);
    mem[{base[31:12], va[31:22], 2'b00}] = pde;
    mem[{pde[31:12], va[21:12], 2'b00}]  = pte;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] b, va, pde, pte;
    void'($urandom(32'h5EED_0042));
    exp_faddr = 32'h0;
    rst_n = 1'b0; root_base = '0; req_valid = 1'b0; req_vaddr = '0;
    req_write = 1'b0; req_user = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 req_ready", 32'(req_ready), 32'h1);
    check("R1 rsp_done", 32'(rsp_done), 32'h0);
    check("R1 rsp_fault", 32'(rsp_fault), 32'h0);
    check("R1 mem_req", 32'(mem_req), 32'h0);
    check("R1 fault_addr", fault_addr, 32'h0);

    b = 32'h0010_0000; va = 32'h1234_5ABC;
    setup(b, va, 32'h0020_0007, 32'h0ABC_D007);
    walk("R4 full perm user write", b, va, 1'b1, 1'b1, 1'b0);

    setup(b, va, 32'h0020_0006, 32'h0ABC_D007);
    walk("R5 root absent", b, va, 1'b0, 1'b0, 1'b0);

    va = 32'h1234_6001;
    setup(b, va, 32'h0020_0007, 32'h0ABC_E006);
    walk("R6 leaf absent", b, va, 1'b0, 1'b0, 1'b0);

    va = 32'h4000_1FFF;
    setup(b, va, 32'h0030_0003, 32'h0111_1007);
    walk("R7 user root US0", b, va, 1'b0, 1'b1, 1'b0);
    walk("R7 supervisor ignores US", b, va, 1'b0, 1'b0, 1'b0);
    setup(b, va, 32'h0030_0007, 32'h0111_1003);
    walk("R7 user leaf US0", b, va, 1'b0, 1'b1, 1'b0);

    va = 32'h8000_2123;
    setup(b, va, 32'h0040_0005, 32'h0222_2007);
    walk("R8 write root RW0", b, va, 1'b1, 1'b0, 1'b0);
    walk("R8 read ignores RW", b, va, 1'b0, 1'b1, 1'b0);
    setup(b, va, 32'h0040_0007, 32'h0222_2005);
    walk("R8 write leaf RW0", b, va, 1'b1, 1'b0, 1'b0);
    walk("R9 hold after success", b, va, 1'b0, 1'b0, 1'b0);

    va = 32'hFFFF_FFFF;
    setup(b, va, 32'h0050_0007, 32'hFFFF_F007);
    walk("R11 flags clear", b, va, 1'b1, 1'b1, 1'b0);
    setup(b, va, 32'h0050_0FFF, 32'hFFFF_FFFF);
    walk("R11 flags set", b, va, 1'b1, 1'b1, 1'b0);
    check("R11 same paddr", rsp_paddr, 32'hFFFF_FFFF);

    b = 32'h0060_0000; va = 32'h0000_0000;
    setup(b, va, 32'h0070_0001, 32'h0333_3001);
    walk("R12 base moved mid-walk", b, va, 1'b0, 1'b0, 1'b1);

    for (int i = 0; i < 300; i++) begin
      b   = {$urandom_range(1, 32'hFFFFE), 12'h000};
      va  = $urandom;
      pde = $urandom;
      pte = $urandom;
      if (pde[31:12] == b[31:12]) pde[31:12] = b[31:12] + 20'd1;
      pde[0] = ($urandom_range(0, 7) != 0);
      pte[0] = ($urandom_range(0, 7) != 0);
      if ($urandom_range(0, 1) == 1) begin pde[2:1] = 2'b11; pte[2:1] = 2'b11; end
      setup(b, va, pde, pte);
      walk("R7 R8 R11 random", b, va, 1'($urandom), 1'($urandom), 1'($urandom));
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule